// File: doc/BRIEF.md
# Triggered Instruction Issue Scheduler

This block is the instruction front end of a processing element that works without a program counter. It keeps a small pool of instruction slots. Each slot carries a guard over the single-bit predicate registers, the head state of the input queues and the room in the output queues. Every cycle all guards are checked at the same time against the current state. The eligible slot with the highest priority is issued. Slot 0 has the highest priority, and the priority falls as the index rises.

An issued slot can also change the predicates by itself, through a set mask and a clear mask that take effect on the issue edge. The datapath can write a single predicate bit later on, through its own port. The slots are programmed through a simple write port while the element is stopped. The issue output drives the datapath, and the dequeue strobes pop the input queues.

Queue flow control is plain status rather than a handshake. An input queue counts as ready when its head-valid flag is high. An output queue applies back-pressure through its full flag, and a full flag blocks every slot that writes to that queue. A dequeue strobe is a single-cycle pop of the queue head, given in the cycle the slot issues.

Top module: `trig_issue_sched`

## Requirements
- R1: A synchronous reset clears all predicate bits to 0 and disables every slot, so no slot issues after reset until slots are written.
- R2: When several slots are eligible in the same cycle, `issue_slot` gives the lowest eligible index. `issue_valid` is high in that same cycle, since the issue decision is combinational on the current state.
- R3: Bit i of a slot's predicate care mask set to 1 requires predicate i to equal bit i of the slot's predicate value. Predicate bits whose care bit is 0 do not affect eligibility.
- R4: When bit q of a slot's need mask is 1, the slot is eligible only if `q_valid[q]` is 1 and the head tag `q_tag[2q+1:2q]` equals the slot's programmed tag for queue q.
- R5: A slot whose output mask has bit o set is not eligible while `out_full[o]` is 1.
- R6: A slot with its enable bit at 0 never issues. In a cycle with no issue, `issue_valid` is 0, `q_deq` is 0, and the predicates change only through a datapath write.
- R7: On the clock edge of an issue, the predicates take the value `(p & ~clr) | set`, using the issued slot's masks, so a set wins over a clear. The next cycle's guard evaluation sees the new value.
- R8: While a slot issues, `q_deq` equals that slot's pop mask, with bit q popping input queue q.
- R9: Configuration writes made while `run` is 1 are ignored and leave the addressed slot unchanged.
- R10: While `run` is 0, no slot issues and no predicate update comes from issue.
- R11: A datapath write with `dp_pred_we` at 1 sets predicate `dp_pred_sel` to `dp_pred_bit` on the next edge. When it meets an issue update on the same bit, the issue update takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | 1 enables issue; 0 allows configuration |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_slot | input | 3 | Slot index to write |
| cfg_enable | input | 1 | Slot enable |
| cfg_pred_care | input | 8 | Predicate care mask |
| cfg_pred_val | input | 8 | Required predicate values |
| cfg_need | input | 4 | Input queues the guard requires |
| cfg_tag | input | 8 | Required head tag, 2 bits per queue, queue q at [2q+1:2q] |
| cfg_pop | input | 4 | Input queues popped on issue |
| cfg_out_wr | input | 2 | Output queues the slot writes |
| cfg_pred_set | input | 8 | Predicates set on issue |
| cfg_pred_clr | input | 8 | Predicates cleared on issue |
| q_valid | input | 4 | Input queue head valid |
| q_tag | input | 8 | Input queue head tags, queue q at [2q+1:2q] |
| out_full | input | 2 | Output queue full flags |
| dp_pred_we | input | 1 | Datapath predicate write |
| dp_pred_sel | input | 3 | Predicate index for the datapath write |
| dp_pred_bit | input | 1 | Value for the datapath write |
| issue_valid | output | 1 | A slot issues this cycle |
| issue_slot | output | 3 | Index of the issued slot |
| q_deq | output | 4 | Dequeue strobes |
| preds | output | 8 | Predicate register state |

## Verification
The bench builds the block with its default parameters: eight slots, eight predicates, four input queues with 2-bit tags and two output queues. At this size every one of the 256 predicate states can be swept. For each state, 64 mixes of queue valid flags, tags and full flags are applied against one fixed pool of eight different guards, including a disabled slot and a catch-all slot. This covers the priority, masking, tag and back-pressure cases together. Separate directed sequences cover the issue-edge predicate masks, the collision with a datapath write, and configuration attempts while running.

// File: rtl/trig_pkg.sv
package trig_pkg;
  parameter int NUM_SLOTS = 8;
  parameter int NUM_PREDS = 8;
  parameter int NUM_INQ   = 4;
  parameter int NUM_OUTQ  = 2;
  parameter int TAG_W     = 2;
  localparam int SLOT_W = $clog2(NUM_SLOTS);
  localparam int PSEL_W = $clog2(NUM_PREDS);
  localparam int TAGS_W = NUM_INQ * TAG_W;

  typedef struct packed {
    logic                 en;
    logic [NUM_PREDS-1:0] care;
    logic [NUM_PREDS-1:0] val;
    logic [NUM_INQ-1:0]   need;
    logic [TAGS_W-1:0]    tag;
    logic [NUM_INQ-1:0]   pop;
    logic [NUM_OUTQ-1:0]  wr;
    logic [NUM_PREDS-1:0] set;
    logic [NUM_PREDS-1:0] clr;
  } slot_cfg_t;
endpackage

// File: rtl/trig_slot_store.sv
module trig_slot_store
  import trig_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [SLOT_W-1:0]        wr_addr,
  input  slot_cfg_t                wr_data,
  output slot_cfg_t [NUM_SLOTS-1:0] slots
);
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)                                       slots[s] <= '0;
      else if (wr_en && wr_addr == SLOT_W'(s))       slots[s] <= wr_data;
    end
  end
endmodule

// File: rtl/trig_match.sv
module trig_match
  import trig_pkg::*;
(
  input  slot_cfg_t [NUM_SLOTS-1:0] slots,
  input  logic [NUM_PREDS-1:0]      preds,
  input  logic [NUM_INQ-1:0]        q_valid,
  input  logic [TAGS_W-1:0]         q_tag,
  input  logic [NUM_OUTQ-1:0]       out_full,
  output logic [NUM_SLOTS-1:0]      hit
);
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_guard
    logic [NUM_INQ-1:0] q_ok;
    for (genvar q = 0; q < NUM_INQ; q++) begin : g_q
      assign q_ok[q] = !slots[s].need[q] ||
                       (q_valid[q] && q_tag[q*TAG_W +: TAG_W] == slots[s].tag[q*TAG_W +: TAG_W]);
    end
    assign hit[s] = slots[s].en
                 && (((preds ^ slots[s].val) & slots[s].care) == '0)
                 && ((slots[s].wr & out_full) == '0)
                 && (&q_ok);
  end
endmodule

// File: rtl/trig_prio.sv
module trig_prio
  import trig_pkg::*;
(
  input  logic [NUM_SLOTS-1:0] req,
  output logic                 any,
  output logic [SLOT_W-1:0]    idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = SLOT_W'(i);
      end
    end
  end
endmodule

// File: rtl/trig_pred_file.sv
module trig_pred_file
  import trig_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 dp_we,
  input  logic [PSEL_W-1:0]    dp_sel,
  input  logic                 dp_bit,
  input  logic                 upd_en,
  input  logic [NUM_PREDS-1:0] upd_set,
  input  logic [NUM_PREDS-1:0] upd_clr,
  output logic [NUM_PREDS-1:0] preds
);
  logic [NUM_PREDS-1:0] nxt;

  always_comb begin
    nxt = preds;
    if (dp_we)  nxt[dp_sel] = dp_bit;
    if (upd_en) nxt = (nxt & ~upd_clr) | upd_set;
  end

  always_ff @(posedge clk) begin
    if (rst) preds <= '0;
    else     preds <= nxt;
  end
endmodule

// File: rtl/trig_issue_sched.sv
module trig_issue_sched
  import trig_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 run,
  input  logic                 cfg_we,
  input  logic [SLOT_W-1:0]    cfg_slot,
  input  logic                 cfg_enable,
  input  logic [NUM_PREDS-1:0] cfg_pred_care,
  input  logic [NUM_PREDS-1:0] cfg_pred_val,
  input  logic [NUM_INQ-1:0]   cfg_need,
  input  logic [TAGS_W-1:0]    cfg_tag,
  input  logic [NUM_INQ-1:0]   cfg_pop,
  input  logic [NUM_OUTQ-1:0]  cfg_out_wr,
  input  logic [NUM_PREDS-1:0] cfg_pred_set,
  input  logic [NUM_PREDS-1:0] cfg_pred_clr,
  input  logic [NUM_INQ-1:0]   q_valid,
  input  logic [TAGS_W-1:0]    q_tag,
  input  logic [NUM_OUTQ-1:0]  out_full,
  input  logic                 dp_pred_we,
  input  logic [PSEL_W-1:0]    dp_pred_sel,
  input  logic                 dp_pred_bit,
  output logic                 issue_valid,
  output logic [SLOT_W-1:0]    issue_slot,
  output logic [NUM_INQ-1:0]   q_deq,
  output logic [NUM_PREDS-1:0] preds
);
  slot_cfg_t                 cfg_word;
  slot_cfg_t [NUM_SLOTS-1:0] slots;
  slot_cfg_t                 sel_cfg;
  logic [NUM_SLOTS-1:0]      hit;

  always_comb begin
    cfg_word.en   = cfg_enable;
    cfg_word.care = cfg_pred_care;
    cfg_word.val  = cfg_pred_val;
    cfg_word.need = cfg_need;
    cfg_word.tag  = cfg_tag;
    cfg_word.pop  = cfg_pop;
    cfg_word.wr   = cfg_out_wr;
    cfg_word.set  = cfg_pred_set;
    cfg_word.clr  = cfg_pred_clr;
  end

  trig_slot_store u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cfg_we && !run),
    .wr_addr (cfg_slot),
    .wr_data (cfg_word),
    .slots   (slots)
  );

  trig_match u_match (
    .slots    (slots),
    .preds    (preds),
    .q_valid  (q_valid),
    .q_tag    (q_tag),
    .out_full (out_full),
    .hit      (hit)
  );

  trig_prio u_prio (
    .req (run ? hit : '0),
    .any (issue_valid),
    .idx (issue_slot)
  );

  assign sel_cfg = slots[issue_slot];
  assign q_deq   = issue_valid ? sel_cfg.pop : '0;

  trig_pred_file u_preds (
    .clk     (clk),
    .rst     (rst),
    .dp_we   (dp_pred_we),
    .dp_sel  (dp_pred_sel),
    .dp_bit  (dp_pred_bit),
    .upd_en  (issue_valid),
    .upd_set (sel_cfg.set),
    .upd_clr (sel_cfg.clr),
    .preds   (preds)
  );
endmodule

// File: rtl/trig_issue_sched_chk.sv
module trig_issue_sched_chk
  import trig_pkg::*;
(
  input logic                 clk,
  input logic                 rst,
  input logic                 run,
  input logic                 issue_valid,
  input logic [NUM_INQ-1:0]   q_deq,
  input logic [NUM_OUTQ-1:0]  out_full,
  input logic [NUM_PREDS-1:0] preds,
  input logic                 dp_pred_we,
  input slot_cfg_t            sel_cfg
);
  AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (rst)
    !run |-> (!issue_valid && q_deq == '0)); // R10
  AST_DEQ_GATED: assert property (@(posedge clk) disable iff (rst)
    !issue_valid |-> q_deq == '0); // R8
  AST_OUT_ROOM: assert property (@(posedge clk) disable iff (rst)
    issue_valid |-> (sel_cfg.wr & out_full) == '0); // R5
  AST_PRED_GUARD: assert property (@(posedge clk) disable iff (rst)
    issue_valid |-> ((preds ^ sel_cfg.val) & sel_cfg.care) == '0); // R3
  AST_SLOT_ENABLED: assert property (@(posedge clk) disable iff (rst)
    issue_valid |-> sel_cfg.en); // R6
  AST_SET_LANDS: assert property (@(posedge clk) disable iff (rst)
    issue_valid |=> (preds & $past(sel_cfg.set)) == $past(sel_cfg.set)); // R7
  AST_PRED_STILL: assert property (@(posedge clk) disable iff (rst)
    (!issue_valid && !dp_pred_we) |=> $stable(preds)); // R6
endmodule

bind trig_issue_sched trig_issue_sched_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .run         (run),
  .issue_valid (issue_valid),
  .q_deq       (q_deq),
  .out_full    (out_full),
  .preds       (preds),
  .dp_pred_we  (dp_pred_we),
  .sel_cfg     (sel_cfg)
);

// File: tb/test_trig_issue_sched.sv
module test_trig_issue_sched;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst, run, cfg_we, cfg_enable, dp_pred_we, dp_pred_bit;
  logic [2:0] cfg_slot, dp_pred_sel;
  logic [7:0] cfg_pred_care, cfg_pred_val, cfg_tag, cfg_pred_set, cfg_pred_clr, q_tag;
  logic [3:0] cfg_need, cfg_pop, q_valid;
  logic [1:0] cfg_out_wr, out_full;
  logic       issue_valid;
  logic [2:0] issue_slot;
  logic [3:0] q_deq;
  logic [7:0] preds;

  int n_chk = 0;
  int n_bad = 0;

  logic       b_en[8];
  logic [7:0] b_care[8], b_val[8], b_tag[8];
  logic [3:0] b_need[8], b_pop[8];
  logic [1:0] b_wr[8];

  trig_issue_sched i_trig_issue_sched (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic put_cfg(input int s, input bit en, input [7:0] care, input [7:0] val,
                         input [3:0] need, input [7:0] tag, input [3:0] pop,
                         input [1:0] wr, input [7:0] set, input [7:0] clr);
    cfg_we = 1; cfg_slot = 3'(s); cfg_enable = en; cfg_pred_care = care; cfg_pred_val = val;
    cfg_need = need; cfg_tag = tag; cfg_pop = pop; cfg_out_wr = wr;
    cfg_pred_set = set; cfg_pred_clr = clr;
    if (!run) begin
      b_en[s] = en; b_care[s] = care; b_val[s] = val; b_need[s] = need;
      b_tag[s] = tag; b_pop[s] = pop; b_wr[s] = wr;
    end
    tick();
    cfg_we = 0;
  endtask

  task automatic load_preds(input [7:0] v);
    for (int i = 0; i < 8; i++) begin
      dp_pred_we = 1; dp_pred_sel = 3'(i); dp_pred_bit = v[i];
      tick();
    end
    dp_pred_we = 0;
  endtask

  function automatic int model(input [7:0] p, input [3:0] v, input [7:0] t, input [1:0] f);
    for (int s = 0; s < 8; s++) begin
      bit ok;
      ok = b_en[s] && (((p ^ b_val[s]) & b_care[s]) == 0) && ((b_wr[s] & f) == 0);
      for (int q = 0; q < 4; q++)
        if (b_need[s][q] && !(v[q] && t[2*q +: 2] == b_tag[s][2*q +: 2])) ok = 0;
      if (ok) return s;
    end
    return -1;
  endfunction

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    chk(0, "watchdog", 0, 1);
    report();
  end

  initial begin
    rst = 1; run = 0; cfg_we = 0; cfg_slot = 0; cfg_enable = 0; cfg_pred_care = 0;
    cfg_pred_val = 0; cfg_need = 0; cfg_tag = 0; cfg_pop = 0; cfg_out_wr = 0;
    cfg_pred_set = 0; cfg_pred_clr = 0; q_valid = 0; q_tag = 0; out_full = 0;
    dp_pred_we = 0; dp_pred_sel = 0; dp_pred_bit = 0;
    for (int s = 0; s < 8; s++) begin
      b_en[s] = 0; b_care[s] = 0; b_val[s] = 0; b_need[s] = 0;
      b_tag[s] = 0; b_pop[s] = 0; b_wr[s] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state, all slots disabled even with everything ready
    run = 1; q_valid = 4'hF;
    #2;
    chk(preds == 0, "R1 preds", preds, 0);
    chk(!issue_valid, "R1 valid", issue_valid, 0);
    tick();
    run = 0;

    // Guard pool for the sweep (no predicate side effects)
    put_cfg(0, 1, 8'hFF, 8'hA5, 4'b0001, 8'b00_00_00_10, 4'b0001, 2'b01, 0, 0);
    put_cfg(1, 1, 8'h0F, 8'h03, 4'b0011, 8'b00_00_11_01, 4'b0010, 2'b10, 0, 0);
    put_cfg(2, 0, 8'h00, 8'h00, 4'b0000, 8'h00, 4'b1111, 2'b00, 0, 0);
    put_cfg(3, 1, 8'h80, 8'h80, 4'b0100, 8'b00_01_00_00, 4'b0100, 2'b00, 0, 0);
    put_cfg(4, 1, 8'hC0, 8'h40, 4'b1000, 8'b00_00_00_00, 4'b1000, 2'b11, 0, 0);
    put_cfg(5, 1, 8'h01, 8'h00, 4'b0000, 8'h00, 4'b0000, 2'b01, 0, 0);
    put_cfg(6, 1, 8'h10, 8'h10, 4'b1111, 8'b11_10_01_00, 4'b1111, 2'b00, 0, 0);
    put_cfg(7, 1, 8'h00, 8'h00, 4'b0000, 8'h00, 4'b0000, 2'b10, 0, 0);

    // R2 R3 R4 R5 R6 R8 R11: sweep all predicate states
    for (int pv = 0; pv < 256; pv++) begin
      run = 0;
      load_preds(8'(pv));
      chk(preds == 8'(pv), "R11 load", preds, pv);
      run = 1;
      for (int k = 0; k < 64; k++) begin
        logic [15:0] h;
        int e;
        h = 16'(k * 37 + pv * 11 + (k << 9));
        q_valid = h[3:0]; q_tag = h[11:4]; out_full = h[13:12];
        #2;
        e = model(8'(pv), q_valid, q_tag, out_full);
        chk(issue_valid == (e >= 0), "R2/R3/R4/R5/R6 valid", issue_valid, e >= 0);
        if (e >= 0) begin
          chk(issue_slot == 3'(e), "R2 slot", issue_slot, e);
          chk(q_deq == b_pop[e], "R8 deq", q_deq, b_pop[e]);
        end else begin
          chk(q_deq == 0, "R6 deq idle", q_deq, 0);
        end
        @(negedge clk);
      end
    end
    run = 0; q_valid = 0; out_full = 0;

    // R7: issue-edge set/clear, set wins, next cycle sees the update
    put_cfg(0, 1, 8'h80, 8'h80, 0, 0, 4'b0101, 0, 8'h0F, 8'hF3);
    for (int s = 1; s < 8; s++) put_cfg(s, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    load_preds(8'hF0);
    run = 1;
    #2;
    chk(issue_valid && issue_slot == 0, "R7 issue", issue_slot, 0);
    chk(q_deq == 4'b0101, "R8 pop mask", q_deq, 4'b0101);
    tick();
    chk(preds == 8'h0F, "R7 update", preds, 8'h0F);
    chk(!issue_valid, "R7 next eval", issue_valid, 0);
    tick();
    chk(preds == 8'h0F, "R6 no side effect", preds, 8'h0F);
    run = 0;

    // R11: datapath write collides with issue set on same bit
    put_cfg(0, 1, 8'h80, 8'h80, 0, 0, 0, 0, 8'h04, 8'h80);
    load_preds(8'h80);
    run = 1;
    dp_pred_we = 1; dp_pred_sel = 3'd2; dp_pred_bit = 0;
    tick();
    chk(preds == 8'h04, "R11 collision", preds, 8'h04);
    dp_pred_sel = 3'd5; dp_pred_bit = 1;
    tick();
    dp_pred_we = 0;
    chk(preds == 8'h24, "R11 plain write", preds, 8'h24);

    // R9: write while running ignored
    put_cfg(3, 1, 0, 0, 0, 0, 0, 0, 8'h01, 0);
    #2;
    chk(!issue_valid, "R9 write during run", issue_valid, 0);
    run = 0;
    tick();
    run = 1;
    #2;
    chk(!issue_valid, "R9 slot unchanged", issue_valid, 0);
    @(negedge clk);
    run = 0;

    // R10: stopped element does not issue
    put_cfg(3, 1, 0, 0, 0, 0, 4'b0011, 0, 8'h01, 0);
    #2;
    chk(!issue_valid, "R10 valid", issue_valid, 0);
    chk(q_deq == 0, "R10 deq", q_deq, 0);
    tick();
    chk(preds == 8'h24, "R10 preds", preds, 8'h24);
    run = 1;
    #2;
    chk(issue_valid && issue_slot == 3, "R10 control issue", issue_slot, 3);
    tick();
    chk(preds == 8'h25, "R7 set after run", preds, 8'h25);
    run = 0;
    tick();
    report();
  end
endmodule